// File: doc/BRIEF.md
# Pipelined ADC Stage-Code Corrector

This block is the digital back end of a four-stage pipelined analog-to-digital converter. Every stage reports a 4-bit coarse code. Adjacent stages run half a clock apart, so the odd-numbered stages report on rising edges and the even-numbered stages report on falling edges. The block captures each code on the edge its stage uses. It moves the falling-edge codes into the rising-edge domain. A delay line per stage then lines up the four codes that belong to one analog sample.

The aligned codes are merged by overlap-add. Each stage is weighted eight times the next, which leaves one redundant bit between neighbours. The merged value has a fixed offset removed and is saturated to the 12-bit range. The result is registered as an offset-binary word: 0 is negative full scale, 0x800 is midscale and 0xFFF is positive full scale. The word comes with a valid flag.

Because of the redundant bit, a stage can decide one code too high or one code too low near a threshold. The following stages absorb that error, and the final word does not change.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `dout_vld` is 0.
- R2: Timing of sample n:
  - Stage 1 (`stg_code_i[3:0]`) is captured on rising edge n.
  - Stage 2 (`[7:4]`) is captured on the falling edge that follows it.
  - Stage 3 (`[11:8]`) is captured on rising edge n+1.
  - Stage 4 (`[15:12]`) is captured on the falling edge after that.
  - The word for sample n is visible after rising edge n+3, and back-to-back samples give words on consecutive rising edges.
- R3: For stage codes c1..c4 (c1 is stage 1), the word is 512*c1 + 64*c2 + 8*c3 + c4 - 292, when that value lies in 0..4095. An ideal input of 2048 yields 0x800.
- R4: Stage codes from an ideal 12-bit quantizer give the same word whether or not stages 1 to 3 each carry a one-code decision error in their redundant bit. The error is +1 when the stage residue is in the upper half of its range and -1 when it is in the lower half.
- R5: A merged value below 0 gives the word 0.
- R6: A merged value above 4095 gives the word 4095.
- R7: `dout_vld` for sample n is high only if all four stage strobes (`stg_vld_i` bit s for stage s+1) were high when that sample's codes were captured. Otherwise `dout_vld` is low and `dout` keeps its previous value.
- R8: After reset is released, `dout_vld` stays low on the first three rising edges, even with valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; even stages are captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_code_i | input | 16 | Four 4-bit stage codes, stage 1 in the low nibble |
| stg_vld_i | input | 4 | Per-stage code strobes, bit 0 for stage 1 |
| dout | output | 12 | Corrected offset-binary word |
| dout_vld | output | 1 | Word valid flag |

## Verification
On the same rising edge, the output register can be asked to saturate a merged value or to hold its previous word, because a strobe in the sample before was dropped.

The bench provokes this with a stream in which a sample with one missing strobe is followed immediately by a sample whose raw codes overflow. The hold edge and the clamp edge are therefore adjacent.

Each output is judged against an independently computed clamp of the weighted sum. The bench also checks that the word held during the gap equals the last valid word.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

   // Clock phase on which a stage presents its code.
   typedef enum logic {
      PH_RISE = 1'b0,
      PH_FALL = 1'b1
   } phase_e;

   // Rising-edge cycle (relative to the sample edge) at which stage idx
   // first sits in a rising-edge register.
   function automatic int realign_cycle(input int idx);
      return (idx + 1) / 2;
   endfunction

   // Cycle at which every stage of one sample is aligned.
   function automatic int align_target(input int n_stages);
      return n_stages / 2;
   endfunction

   // Rising edges from sample capture to the output register.
   function automatic int word_latency(input int n_stages);
      return n_stages / 2 + 1;
   endfunction

endpackage

// File: rtl/adc_stage_capture.sv
module adc_stage_capture
   import adc_corr_pkg::*;
#(
   parameter int     CODE_W = 4,
   parameter phase_e PHASE  = PH_RISE,
   parameter int     EXTRA  = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              vld_i,
   output logic [CODE_W-1:0] code_o,
   output logic              vld_o
);

   logic [CODE_W-1:0] first_code;
   logic              first_vld;

   generate
      if (CODE_W < 1) begin : g_bad_width
         $error("adc_stage_capture: CODE_W must be positive");
      end
      if (EXTRA < 0) begin : g_bad_extra
         $error("adc_stage_capture: EXTRA must not be negative");
      end

      if (PHASE == PH_FALL) begin : g_fall
         logic [CODE_W-1:0] half_code;
         logic              half_vld;

         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               half_code <= '0;
               half_vld  <= 1'b0;
            end else begin
               half_code <= code_i;
               half_vld  <= vld_i;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               first_code <= '0;
               first_vld  <= 1'b0;
            end else begin
               first_code <= half_code;
               first_vld  <= half_vld;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               first_code <= '0;
               first_vld  <= 1'b0;
            end else begin
               first_code <= code_i;
               first_vld  <= vld_i;
            end
         end
      end

      if (EXTRA == 0) begin : g_no_delay
         assign code_o = first_code;
         assign vld_o  = first_vld;
      end else begin : g_delay
         logic [CODE_W-1:0] line_code [EXTRA];
         logic              line_vld  [EXTRA];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < EXTRA; k++) begin
                  line_code[k] <= '0;
                  line_vld[k]  <= 1'b0;
               end
            end else begin
               line_code[0] <= first_code;
               line_vld[0]  <= first_vld;
               for (int k = 1; k < EXTRA; k++) begin
                  line_code[k] <= line_code[k-1];
                  line_vld[k]  <= line_vld[k-1];
               end
            end
         end

         assign code_o = line_code[EXTRA-1];
         assign vld_o  = line_vld[EXTRA-1];
      end
   endgenerate

endmodule

// File: rtl/adc_code_merge.sv
module adc_code_merge #(
   parameter int N_STAGES = 4,
   parameter int CODE_W   = 4,
   parameter int SHIFT    = 3,
   parameter int OUT_W    = 12,
   parameter int OFFSET   = 292
)(
   input  logic [N_STAGES*CODE_W-1:0] codes_i,
   output logic [OUT_W-1:0]           word_o
);

   localparam int ACC_W = CODE_W + SHIFT * (N_STAGES - 1) + 1;
   localparam int DIF_W = ACC_W + 1;

   localparam logic signed [DIF_W-1:0] OFS_S = DIF_W'(OFFSET);
   localparam logic signed [DIF_W-1:0] TOP_S = DIF_W'((2 ** OUT_W) - 1);

   logic [ACC_W-1:0]        term [N_STAGES];
   logic [ACC_W-1:0]        acc;
   logic signed [DIF_W-1:0] diff;

   generate
      if (ACC_W <= OUT_W) begin : g_bad_acc
         $error("adc_code_merge: accumulator narrower than output");
      end
      for (genvar s = 0; s < N_STAGES; s++) begin : g_term
         assign term[s] = ACC_W'(codes_i[s*CODE_W +: CODE_W]) << (SHIFT * (N_STAGES - 1 - s));
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int s = 0; s < N_STAGES; s++) begin
         acc = acc + term[s];
      end
   end

   always_comb begin
      diff = $signed({1'b0, acc}) - OFS_S;
      if (diff < 0) begin
         word_o = '0;
      end else if (diff > TOP_S) begin
         word_o = '1;
      end else begin
         word_o = diff[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/adc_out_reg.sv
module adc_out_reg #(
   parameter int OUT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W-1:0] word_i,
   input  logic             vld_i,
   output logic [OUT_W-1:0] word_o,
   output logic             vld_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            word_o <= word_i;
         end
      end
   end

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
   import adc_corr_pkg::*;
#(
   parameter int N_STAGES = 4,
   parameter int CODE_W   = 4,
   parameter int SHIFT    = 3,
   parameter int OUT_W    = 12,
   parameter int OFFSET   = 292
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_STAGES*CODE_W-1:0] stg_code_i,
   input  logic [N_STAGES-1:0]        stg_vld_i,
   output logic [OUT_W-1:0]           dout,
   output logic                       dout_vld
);

   localparam int ALIGN_AT = align_target(N_STAGES);

   logic [N_STAGES*CODE_W-1:0] aligned_code;
   logic [N_STAGES-1:0]        aligned_vld;
   logic [OUT_W-1:0]           merged_word;

   generate
      if (N_STAGES < 2) begin : g_bad_stages
         $error("pipe_adc_corrector: at least two stages needed");
      end
      if (SHIFT >= CODE_W || SHIFT < 1) begin : g_bad_shift
         $error("pipe_adc_corrector: SHIFT must leave a redundant bit");
      end
      if (OUT_W > CODE_W + SHIFT * (N_STAGES - 1)) begin : g_bad_out
         $error("pipe_adc_corrector: OUT_W exceeds resolved bits");
      end
      if (OFFSET < 0) begin : g_bad_offset
         $error("pipe_adc_corrector: OFFSET must not be negative");
      end

      for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
         adc_stage_capture #(
            .CODE_W (CODE_W),
            .PHASE  ((s % 2 == 1) ? PH_FALL : PH_RISE),
            .EXTRA  (ALIGN_AT - realign_cycle(s))
         ) cap_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .code_i (stg_code_i[s*CODE_W +: CODE_W]),
            .vld_i  (stg_vld_i[s]),
            .code_o (aligned_code[s*CODE_W +: CODE_W]),
            .vld_o  (aligned_vld[s])
         );
      end
   endgenerate

   adc_code_merge #(
      .N_STAGES (N_STAGES),
      .CODE_W   (CODE_W),
      .SHIFT    (SHIFT),
      .OUT_W    (OUT_W),
      .OFFSET   (OFFSET)
   ) merge_i (
      .codes_i (aligned_code),
      .word_o  (merged_word)
   );

   adc_out_reg #(
      .OUT_W (OUT_W)
   ) out_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .word_i (merged_word),
      .vld_i  (&aligned_vld),
      .word_o (dout),
      .vld_o  (dout_vld)
   );

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk
   import adc_corr_pkg::*;
#(
   parameter int N_STAGES = 4,
   parameter int OUT_W    = 12
)(
   input logic             clk,
   input logic             rst_n,
   input logic             s0_vld,
   input logic [OUT_W-1:0] dout,
   input logic             dout_vld
);

   localparam int LAT = word_latency(N_STAGES);

   logic [7:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (edge_cnt != 8'hFF) begin
         edge_cnt <= edge_cnt + 8'd1;
      end
   end

   // R1: output cleared while reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (dout == '0 && !dout_vld));

   // R8: no valid word until the pipeline has filled
   p_fill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(edge_cnt) <= LAT) |-> !dout_vld);

   // R7: data holds whenever the flag is low
   p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> $stable(dout));

   // R7: a valid word needs the first-stage strobe of its sample
   p_vld_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(s0_vld, LAT + 1));

endmodule

bind pipe_adc_corrector adc_corr_chk #(
   .N_STAGES (N_STAGES),
   .OUT_W    (OUT_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .s0_vld   (stg_vld_i[0]),
   .dout     (dout),
   .dout_vld (dout_vld)
);

// File: tb/pipe_adc_corrector_tb_top.sv
module pipe_adc_corrector_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NS   = 4;
   localparam int CW   = 4;
   localparam int OW   = 12;
   localparam int OFS  = 292;
   localparam int MAXS = 64;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [NS*CW-1:0] stg_code;
   logic [NS-1:0]    stg_vld;
   logic [OW-1:0]    dout;
   logic             dout_vld;

   int n_chk = 0;
   int n_bad = 0;
   int qn    = 0;
   int last_word = 0;
   int qc [MAXS][NS];
   bit qv [MAXS][NS];

   always #2.5 clk = ~clk;

   pipe_adc_corrector dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .stg_code_i (stg_code),
      .stg_vld_i  (stg_vld),
      .dout       (dout),
      .dout_vld   (dout_vld)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_word(input int m);
      int s;
      s = 512 * qc[m][0] + 64 * qc[m][1] + 8 * qc[m][2] + qc[m][3] - OFS;
      if (s < 0) return 0;
      if (s > 4095) return 4095;
      return s;
   endfunction

   function automatic bit all_v(input int m);
      return qv[m][0] & qv[m][1] & qv[m][2] & qv[m][3];
   endfunction

   // Ideal quantizer with optional one-code decision errors in stages 1..3.
   task automatic put_ideal(input int idx, input int x, input bit [2:0] err);
      int c1, c2, c3, r1, r2, r3;
      c1 = x / 512;
      r1 = x - 512 * c1;
      if (err[0]) begin
         if (r1 >= 256) c1++;
         else if (c1 > 0) c1--;
      end
      r1 = x - 512 * c1;
      c2 = (r1 + 256) / 64;
      r2 = r1 + 256 - 64 * c2;
      if (err[1]) begin
         if (r2 >= 32) c2++;
         else if (c2 > 0) c2--;
      end
      r2 = r1 + 256 - 64 * c2;
      c3 = (r2 + 32) / 8;
      r3 = r2 + 32 - 8 * c3;
      if (err[2]) begin
         if (r3 >= 4) c3++;
         else if (c3 > 0) c3--;
      end
      r3 = r2 + 32 - 8 * c3;
      qc[idx][0] = c1; qc[idx][1] = c2; qc[idx][2] = c3; qc[idx][3] = r3 + 4;
      for (int s = 0; s < NS; s++) qv[idx][s] = 1'b1;
   endtask

   task automatic put_raw(input int idx, input int c1, input int c2, input int c3,
                          input int c4, input bit [3:0] vm);
      qc[idx][0] = c1; qc[idx][1] = c2; qc[idx][2] = c3; qc[idx][3] = c4;
      for (int s = 0; s < NS; s++) qv[idx][s] = vm[s];
   endtask

   // Drive qn samples with the staggered stage timing and check every word.
   task automatic run_stream(input string req);
      for (int k = 0; k < qn + 3; k++) begin
         @(negedge clk);
         #0.5;
         stg_code = '0;
         stg_vld  = '0;
         if (k < qn) begin
            stg_code[3:0] = CW'(qc[k][0]);
            stg_code[7:4] = CW'(qc[k][1]);
            stg_vld[0]    = qv[k][0];
            stg_vld[1]    = qv[k][1];
         end
         if (k >= 1 && k - 1 < qn) begin
            stg_code[11:8]  = CW'(qc[k-1][2]);
            stg_code[15:12] = CW'(qc[k-1][3]);
            stg_vld[2]      = qv[k-1][2];
            stg_vld[3]      = qv[k-1][3];
         end
         @(posedge clk);
         #0.5;
         if (k >= 3 && all_v(k - 3)) begin
            check({req, " word"}, int'(dout), ref_word(k - 3));
            check({req, " flag"}, int'(dout_vld), 1);
            last_word = ref_word(k - 3);
         end else if (k >= 3) begin
            check("R7 flag low on gap", int'(dout_vld), 0);
            check("R7 word held on gap", int'(dout), last_word);
         end else begin
            check("R8 flag low while filling", int'(dout_vld), 0);
            check("R8 word held while filling", int'(dout), last_word);
         end
      end
   endtask

   task automatic t_reset();
      rst_n    = 1'b0;
      stg_code = '0;
      stg_vld  = '0;
      repeat (4) @(posedge clk);
      #0.5;
      check("R1 word in reset", int'(dout), 0);
      check("R1 flag in reset", int'(dout_vld), 0);
      @(negedge clk);
      #0.5;
      rst_n     = 1'b1;
      last_word = 0;
   endtask

   task automatic t_ideal_stream();
      int xs [12] = '{2048, 0, 4095, 1, 4094, 511, 512, 1000, 2047, 2049, 3333, 77};
      qn = 12;
      for (int i = 0; i < 12; i++) put_ideal(i, xs[i], 3'b000);
      check("R3 midscale code", ref_word(0), 2048);
      run_stream("R2 R3 ideal");
   endtask

   task automatic t_redundancy();
      int xs [8] = '{0, 255, 256, 2047, 2048, 3000, 3711, 4095};
      qn = 0;
      for (int i = 0; i < 8; i++) begin
         for (int e = 1; e < 8; e++) begin
            put_ideal(qn, xs[i], 3'(e));
            check("R4 reference self", ref_word(qn), xs[i]);
            qn++;
         end
      end
      run_stream("R4 corrected");
   endtask

   task automatic t_clamp();
      qn = 6;
      put_raw(0, 0, 0, 0, 0, 4'hF);     // -292 -> 0
      put_raw(1, 0, 4, 4, 4, 4'hF);     // exactly 0
      put_raw(2, 0, 4, 4, 3, 4'hF);     // -1 -> 0
      put_raw(3, 8, 4, 4, 3, 4'hF);     // 4095
      put_raw(4, 8, 4, 4, 4, 4'hF);     // 4096 -> 4095
      put_raw(5, 15, 15, 15, 15, 4'hF); // far above -> 4095
      check("R5 expect low clamp", ref_word(2), 0);
      check("R6 expect high clamp", ref_word(4), 4095);
      run_stream("R5 R6 clamp");
   endtask

   task automatic t_gaps();
      qn = 10;
      put_ideal(0, 1234, 3'b000);
      put_ideal(1, 2222, 3'b101);
      put_raw(2, 4, 4, 4, 4, 4'b1101);   // stage 2 strobe missing
      put_raw(3, 15, 15, 15, 15, 4'hF);  // saturating right after the gap
      put_raw(4, 5, 5, 5, 5, 4'b0111);   // stage 4 strobe missing
      put_raw(5, 5, 5, 5, 5, 4'b0000);
      put_ideal(6, 900, 3'b010);
      put_raw(7, 6, 6, 6, 6, 4'b1110);   // stage 1 strobe missing
      put_raw(8, 0, 0, 0, 0, 4'hF);      // low clamp after gap
      put_ideal(9, 4000, 3'b111);
      run_stream("R7 gaps");
   endtask

   initial begin
      t_reset();
      t_ideal_stream();
      t_redundancy();
      t_clamp();
      t_gaps();
      t_reset();
      t_ideal_stream();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule